// File: doc/BRIEF.md
# DSP Instruction Address Sequencer with Debug Control

This block drives the instruction address of a DSP core whose program sits in a fixed store of up to 512 slots. When a sample-start strobe arrives while the core is idle, the sequencer begins at slot zero and issues one instruction per clock. At the last slot it wraps to zero and waits for the next strobe. A conditional skip, requested by the ALU together with a bit mask and a count, jumps the address forward over that many instructions when every masked bit of the held condition code is set.

A 32-bit debug word controls the sequencer and reports its state. Through it, software can stop the program and step it one instruction at a time from an address it chooses. It also reports the address of the first instruction that saturated, the condition code and the current address. Writing it can also pulse a clear to the delay-memory base counter. The ALU, the instruction store and the delay memory sit outside this block.

Top module: `dsp_seq`

## Requirements
- R1: After reset `pc` is 0, `issue` is 0, `dbase_zero` is 0 and `dbg_rdata` reads 0.
- R2: A `frame_start` pulse while idle and not in step mode starts a pass: from the next cycle `issue` is 1 and `pc` runs 0, 1, 2, ... one address per cycle.
- R3: When the address would pass slot NSLOT-1, `pc` returns to 0 and `issue` drops until the next `frame_start`. A `frame_start` during a pass has no effect on the address sequence.
- R4: In an issue cycle with `skip_req` high, if `(cc & skip_mask) == skip_mask` the next address is `pc + 1 + skip_cnt`. Otherwise it is `pc + 1`. Here `cc` is the held condition code.
- R5: A skip that lands at or beyond NSLOT ends the pass the same way as R3.
- R6: A cycle with `cc_we` high loads `cc_in` into the held condition code, which reads back in `dbg_rdata[13:9]`.
- R7: The first saturation during an issue cycle sets `dbg_rdata[25]` and stores that cycle's `pc` in `dbg_rdata[24:16]`. Later saturations leave both unchanged while the flag is set.
- R8: A debug write with bit 25 at 0 clears the saturation flag and re-arms the capture. A write with bit 25 at 1 leaves the flag and the stored address unchanged.
- R9: A debug write with bit 15 at 1 enters step mode and loads `pc` from bits 8:0 with no instruction issued. In step mode `frame_start` is ignored. `dbg_rdata[15]` reads the mode, and `dbg_rdata[8:0]` reads the current `pc`.
- R10: A debug write with bits 15 and 14 both at 1 issues exactly one instruction at the loaded address in the next cycle. `pc` then holds the following address, which is 0 after the last slot.
- R11: A debug write with bit 15 at 0 while in step mode leaves step mode with `pc` at 0, idle until `frame_start`.
- R12: A debug write with bit 31 at 1 gives a one-cycle `dbase_zero` pulse in the following cycle. `dbg_rdata` bits 31:26 and 14 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Sample-period start strobe |
| sat_evt | input | 1 | ALU saturated on the instruction issued this cycle |
| cc_we | input | 1 | Load the condition code |
| cc_in | input | 5 | New condition code from the ALU |
| skip_req | input | 1 | Current instruction requests a conditional skip |
| skip_mask | input | 5 | Condition bits that must all be set for the skip |
| skip_cnt | input | 9 | Number of instructions to skip |
| dbg_we | input | 1 | Debug word write strobe |
| dbg_wdata | input | 32 | Debug word write data |
| pc | output | 9 | Instruction address |
| issue | output | 1 | An instruction is issued at `pc` this cycle |
| dbg_rdata | output | 32 | Debug readback word |
| dbase_zero | output | 1 | One-cycle clear of the delay-memory base counter |

## Verification
The address sequence is checked against a scoreboard over four kinds of pass:
- a plain pass, which shows the count and the wrap;
- a pass with a skip whose mask matches, and one whose mask does not, which separate the condition test from the jump;
- a pass whose skip runs past the end, which shows that overflow ends the pass rather than aliasing;
- a pass with a stray `frame_start`, which shows that a pass cannot be restarted.

Saturation passes with two events show that only the first is kept. The writes that re-arm the capture and the writes that leave it alone are compared by their effect on the next pass. Step writes at a middle address and at the last slot check that exactly one issue occurs, and where the address stops.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
  localparam int ADDR_W = 9;
  localparam int CC_W   = 5;

  // debug word field positions (software decodes these)
  localparam int BIT_DBZ   = 31;
  localparam int BIT_SATF  = 25;
  localparam int SATA_LO   = 16;
  localparam int BIT_STEPM = 15;
  localparam int BIT_STEPG = 14;
  localparam int CC_LO     = 9;

  function automatic logic [ADDR_W:0] seq_advance(input logic [ADDR_W-1:0] cur,
                                                   input logic take,
                                                   input logic [ADDR_W-1:0] cnt);
    logic [ADDR_W:0] jump;
    jump = take ? {1'b0, cnt} : '0;
    return {1'b0, cur} + jump + {{ADDR_W{1'b0}}, 1'b1};
  endfunction

  function automatic logic cond_match(input logic [CC_W-1:0] cc, input logic [CC_W-1:0] mask);
    return (cc & mask) == mask;
  endfunction

  function automatic logic [31:0] pack_dbg(input logic sat_f, input logic [ADDR_W-1:0] sat_a,
                                           input logic step_m, input logic [CC_W-1:0] cc,
                                           input logic [ADDR_W-1:0] cur);
    return {6'b0, sat_f, sat_a, step_m, 1'b0, cc, cur};
  endfunction
endpackage

// File: rtl/dseq_dbg_ctl.sv
module dseq_dbg_ctl
  import dseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_we,
  input  logic [31:0]       dbg_wdata,
  input  logic              cc_we,
  input  logic [CC_W-1:0]   cc_in,
  output logic              step_mode,
  output logic              step_load,
  output logic              step_go,
  output logic              step_exit,
  output logic [ADDR_W-1:0] step_addr,
  output logic              sat_clr,
  output logic [CC_W-1:0]   cc_q,
  output logic              dbase_zero
);
  logic unused_wbits;
  assign unused_wbits = ^{dbg_wdata[30:26], dbg_wdata[24:16], dbg_wdata[13:9]};

  assign step_load = dbg_we & dbg_wdata[BIT_STEPM];
  assign step_go   = step_load & dbg_wdata[BIT_STEPG];
  assign step_exit = dbg_we & ~dbg_wdata[BIT_STEPM] & step_mode;
  assign step_addr = dbg_wdata[ADDR_W-1:0];
  assign sat_clr   = dbg_we & ~dbg_wdata[BIT_SATF];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_mode  <= 1'b0;
      cc_q       <= '0;
      dbase_zero <= 1'b0;
    end else begin
      if (dbg_we) step_mode <= dbg_wdata[BIT_STEPM];
      if (cc_we)  cc_q      <= cc_in;
      dbase_zero <= dbg_we & dbg_wdata[BIT_DBZ];
    end
  end

  AST_DBZ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dbase_zero && !(dbg_we && dbg_wdata[BIT_DBZ])) |=> !dbase_zero); // R12
  AST_CC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cc_we |=> $stable(cc_q)); // R6
endmodule

// File: rtl/dseq_sat_cap.sv
module dseq_sat_cap
  import dseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic              sat_evt,
  input  logic              clr,
  output logic              sat_flag,
  output logic [ADDR_W-1:0] sat_addr
);
  logic first_hit;
  assign first_hit = issue & sat_evt & ~sat_flag & ~clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sat_flag <= 1'b0;
      sat_addr <= '0;
    end else if (clr) begin
      sat_flag <= 1'b0;
    end else if (first_hit) begin
      sat_flag <= 1'b1;
      sat_addr <= cur_pc;
    end
  end

  AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !clr) |=> (sat_flag && $stable(sat_addr))); // R7
  AST_SAT_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !sat_flag); // R8
endmodule

// File: rtl/dseq_addr_ctl.sv
module dseq_addr_ctl
  import dseq_pkg::*;
#(
  parameter int NSLOT = 512
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              step_mode,
  input  logic              step_load,
  input  logic              step_go,
  input  logic              step_exit,
  input  logic [ADDR_W-1:0] step_addr,
  input  logic              skip_take,
  input  logic [ADDR_W-1:0] skip_cnt,
  output logic [ADDR_W-1:0] pc_q,
  output logic              issue,
  output logic              pass_end
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NSLOT);

  logic            run_q, pend_q;
  logic [ADDR_W:0] nxt;
  logic            over;

  assign issue    = run_q | pend_q;
  assign nxt      = seq_advance(pc_q, skip_take, skip_cnt);
  assign over     = nxt >= LIMIT;
  assign pass_end = issue & over;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (step_load) begin
      pc_q   <= step_addr;
      run_q  <= 1'b0;
      pend_q <= step_go;
    end else if (step_exit) begin
      pc_q   <= '0;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (issue) begin
      pc_q   <= over ? '0 : nxt[ADDR_W-1:0];
      pend_q <= 1'b0;
      if (over) run_q <= 1'b0;
    end else if (frame_start && !step_mode) begin
      pc_q  <= '0;
      run_q <= 1'b1;
    end
  end

  AST_PC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, pc_q} < LIMIT); // R2
  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (pc_q == '0)); // R2
  AST_PASS_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_end && !step_load && !step_exit) |=> (pc_q == '0 && !run_q)); // R3
  AST_SKIP_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && skip_take && !over && !step_load && !step_exit) |=>
      ({1'b0, pc_q} == {1'b0, $past(pc_q)} + {1'b0, $past(skip_cnt)} + 1'b1)); // R4
  AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !step_load) |=> !issue); // R10
endmodule

// File: rtl/dsp_seq.sv
module dsp_seq
  import dseq_pkg::*;
#(
  parameter int NSLOT = 512
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_start,
  input  logic        sat_evt,
  input  logic        cc_we,
  input  logic [4:0]  cc_in,
  input  logic        skip_req,
  input  logic [4:0]  skip_mask,
  input  logic [8:0]  skip_cnt,
  input  logic        dbg_we,
  input  logic [31:0] dbg_wdata,
  output logic [8:0]  pc,
  output logic        issue,
  output logic [31:0] dbg_rdata,
  output logic        dbase_zero
);
  logic              step_mode, step_load, step_go, step_exit, sat_clr;
  logic [ADDR_W-1:0] step_addr, sat_addr;
  logic [CC_W-1:0]   cc_q;
  logic              sat_flag, skip_take, pass_end;

  assign skip_take = issue & skip_req & cond_match(cc_q, skip_mask);

  dseq_dbg_ctl u_dbg (
    .clk(clk), .rst_n(rst_n), .dbg_we(dbg_we), .dbg_wdata(dbg_wdata),
    .cc_we(cc_we), .cc_in(cc_in), .step_mode(step_mode), .step_load(step_load),
    .step_go(step_go), .step_exit(step_exit), .step_addr(step_addr),
    .sat_clr(sat_clr), .cc_q(cc_q), .dbase_zero(dbase_zero)
  );

  dseq_addr_ctl #(.NSLOT(NSLOT)) u_addr (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .step_mode(step_mode),
    .step_load(step_load), .step_go(step_go), .step_exit(step_exit),
    .step_addr(step_addr), .skip_take(skip_take), .skip_cnt(skip_cnt),
    .pc_q(pc), .issue(issue), .pass_end(pass_end)
  );

  dseq_sat_cap u_sat (
    .clk(clk), .rst_n(rst_n), .issue(issue), .cur_pc(pc), .sat_evt(sat_evt),
    .clr(sat_clr), .sat_flag(sat_flag), .sat_addr(sat_addr)
  );

  assign dbg_rdata = pack_dbg(sat_flag, sat_addr, step_mode, cc_q, pc);

  AST_STEP_NO_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (step_mode && !issue && !dbg_we) |=> !issue); // R9
endmodule

// File: tb/dsp_seq_bench.sv
module dsp_seq_bench;
  localparam int N = 32;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        frame_start = 0, sat_evt = 0, cc_we = 0, skip_req = 0, dbg_we = 0;
  logic [4:0]  cc_in = 0, skip_mask = 0;
  logic [8:0]  skip_cnt = 0;
  logic [31:0] dbg_wdata = 0;
  logic [8:0]  pc;
  logic        issue, dbase_zero;
  logic [31:0] dbg_rdata;

  int    n_chk = 0, n_err = 0;
  int    exp_q[$];
  string cur_req = "R2";
  logic [4:0] cc_model = 0;

  always #5 clk = ~clk;

  dsp_seq #(.NSLOT(N)) u_dsp_seq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .sat_evt(sat_evt),
    .cc_we(cc_we), .cc_in(cc_in), .skip_req(skip_req), .skip_mask(skip_mask),
    .skip_cnt(skip_cnt), .dbg_we(dbg_we), .dbg_wdata(dbg_wdata), .pc(pc),
    .issue(issue), .dbg_rdata(dbg_rdata), .dbase_zero(dbase_zero)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: every issued address must match the next scoreboard entry
  always @(negedge clk) begin
    if (rst_n && issue) begin
      if (exp_q.size() == 0) check(0, "R3 unexpected issue", pc, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        check(pc == e[8:0], cur_req, pc, e);
      end
    end
  end

  task automatic dwrite(input logic [31:0] d);
    dbg_wdata = d; dbg_we = 1;
    @(negedge clk);
    dbg_we = 0; dbg_wdata = 0;
  endtask

  task automatic fstart();
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
  endtask

  task automatic set_cc(input logic [4:0] v);
    cc_in = v; cc_we = 1; cc_model = v;
    @(negedge clk);
    cc_we = 0;
  endtask

  // driver: computes the expected sequence, then drives one pass
  task automatic run_pass(input string req, input int skip_at, input logic [4:0] mask,
                          input int cnt, input int sat_a, input int sat_b, input int stray);
    int p = 0;
    cur_req = req;
    while (p < N) begin
      exp_q.push_back(p);
      if (p == skip_at && ((cc_model & mask) == mask)) p = p + 1 + cnt;
      else p = p + 1;
    end
    skip_mask = mask; skip_cnt = cnt[8:0];
    fstart();
    for (int i = 0; i < N + 4; i++) begin
      skip_req    = issue && (int'(pc) == skip_at);
      sat_evt     = issue && (int'(pc) == sat_a || int'(pc) == sat_b);
      frame_start = (i == stray);
      @(negedge clk);
    end
    skip_req = 0; sat_evt = 0; frame_start = 0;
    check(exp_q.size() == 0, {req, " sequence length"}, exp_q.size(), 0);
    check(pc == 0 && !issue, "R3 idle at 0 after pass", {pc, issue}, 0);
  endtask

  initial begin
    #2_000_000;
    check(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pc == 0 && !issue && dbg_rdata == 0 && !dbase_zero, "R1 reset", dbg_rdata, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(!issue, "R2 idle before strobe", issue, 0);

    run_pass("R2 plain pass", -1, 0, 0, -1, -1, -1);
    run_pass("R3 stray strobe", -1, 0, 0, -1, -1, 10);

    set_cc(5'b00101);
    check(dbg_rdata[13:9] == 5'b00101, "R6 cc readback", dbg_rdata[13:9], 5);
    run_pass("R4 skip taken", 4, 5'b00100, 3, -1, -1, -1);
    run_pass("R4 skip not taken", 4, 5'b00110, 3, -1, -1, -1);
    run_pass("R5 skip past end", 30, 5'b00001, 5, -1, -1, -1);

    run_pass("R7 sat pass", -1, 0, 0, 6, 10, -1);
    check(dbg_rdata[25] && dbg_rdata[24:16] == 6, "R7 first saturation", dbg_rdata[25:16], 10'h206);
    dwrite(32'h0200_0000);
    check(dbg_rdata[25] && dbg_rdata[24:16] == 6, "R8 bit25=1 keeps flag", dbg_rdata[25:16], 10'h206);
    dwrite(32'h0000_0000);
    check(!dbg_rdata[25], "R8 clear", dbg_rdata[25], 0);
    run_pass("R8 rearmed pass", -1, 0, 0, 12, 20, -1);
    check(dbg_rdata[25] && dbg_rdata[24:16] == 12, "R8 rearmed capture", dbg_rdata[25:16], 10'h20c);

    dwrite(32'h8200_0000);
    check(dbase_zero, "R12 clear pulse", dbase_zero, 1);
    check(dbg_rdata[31:26] == 0 && !dbg_rdata[14], "R12 reserved bits", dbg_rdata, 0);
    @(negedge clk);
    check(!dbase_zero, "R12 single cycle", dbase_zero, 0);

    dwrite(32'h0000_8005);
    check(pc == 5 && !issue && dbg_rdata[15], "R9 enter step", dbg_rdata[15:0], 16'h8005);
    fstart();
    repeat (3) @(negedge clk);
    check(pc == 5 && !issue, "R9 strobe ignored", pc, 5);

    cur_req = "R10 step issue";
    exp_q.push_back(5);
    dwrite(32'h0000_C005);
    @(negedge clk);
    check(pc == 6 && !issue && exp_q.size() == 0, "R10 one step", pc, 6);
    exp_q.push_back(N - 1);
    dwrite(32'h0000_C000 | (N - 1));
    @(negedge clk);
    check(pc == 0 && !issue && exp_q.size() == 0, "R10 step at last slot", pc, 0);

    dwrite(32'h0000_8007);
    dwrite(32'h0000_0000);
    check(pc == 0 && !issue && !dbg_rdata[15], "R11 leave step", dbg_rdata[15:0], 0);
    run_pass("R11 free run resumes", -1, 0, 0, -1, -1, -1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule